// File: doc/BRIEF.md
# Exception return control unit

This unit keeps the privileged status word, a debug-mode flag, three return-address registers and the load-linked reservation address of a 32-bit core. On request it also carries out the small control commands that change them. The pipeline issues at most one command per cycle by raising `cmd_valid` with a 3-bit code. The unit can take a command in every cycle, so it has no back-pressure and no ready signal. The command codes are: 0 turns interrupts off, 1 turns interrupts on, 2 is an exception return that also drops the reservation, 3 is an exception return that keeps the reservation, and 4 is a debug return. Codes 5 to 7 are not defined.

A return command produces a registered redirect one cycle later. The redirect holds the new program counter and a mode bit that is taken from bit 0 of the chosen return address. The effective privilege mode is worked out again from the status word and the debug flag. When no command is in progress, plain write ports can load the status word, the return addresses and the reservation address. A separate strobe marks entry into debug mode.

Status layout: bit 0 is the interrupt enable, bit 1 is the exception level, bit 2 is the error level, and bits 4:3 hold the requested user/supervisor mode. The return-address slots are numbered 0 for the exception address, 1 for the error address and 2 for the debug address.

Top module: `xret_ctrl_unit`

## Requirements
- R1: After reset the status word is 32'h4 (error level set, interrupts off), debug mode is clear, `lladdr` is 1, `redir_valid` is low and `priv_mode` is 3.
- R2: Code 0 clears status bit 0. The status word as it was before the command appears on `old_status` after the next clock edge.
- R3: Code 1 sets status bit 0. The status word as it was before the command appears on `old_status` after the next clock edge.
- R4: For codes 2 and 3, when status bit 2 is set, the redirect target comes from slot 1 and only bit 2 is cleared.
- R5: For codes 2 and 3, when status bit 2 is clear, the redirect target comes from slot 0 and bit 1 is cleared.
- R6: Code 2 writes 1 into `lladdr` and wins over a reservation write in the same cycle. Code 3 leaves `lladdr` alone, so only a same-cycle write can change it.
- R7: Code 4 redirects to slot 2 and clears debug mode. Status bits 1 and 2 are not changed.
- R8: `priv_mode` follows these rules, applied in order: 3 if status bit 2 is set; otherwise 0 if bit 1 or debug mode is set; otherwise 2 if bit 4 is set, 1 if bits 4:3 are 01, and 0 if they are 00.
- R9: `redir_valid` is high for exactly the one cycle after an accepted code 2, 3 or 4. Codes 0, 1 and 5 to 7 never raise it. Codes 5 to 7 change no state.
- R10: `redir_isa` equals bit 0 of the chosen return address, and bit 0 of `redir_pc` is always 0.
- R11: A return-address write in the same cycle as a return uses the old value for the redirect and stores the new value for later returns. While `cmd_valid` is high, a status write and a debug-entry strobe are dropped.
- R12: When no command is present, `st_we` loads the whole status word, `dbg_enter` sets debug mode, and `ra_we` loads the slot chosen by `ra_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| st_we | input | 1 | Status word write enable |
| st_wdata | input | 32 | Status word write value |
| dbg_enter | input | 1 | Set debug mode |
| ra_we | input | 1 | Return-address write enable |
| ra_sel | input | 2 | Return-address slot (0 exception, 1 error, 2 debug) |
| ra_wdata | input | 32 | Return-address write value |
| ll_we | input | 1 | Reservation address write enable |
| ll_wdata | input | 32 | Reservation address write value |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Redirect target with bit 0 cleared |
| redir_isa | output | 1 | Bit 0 of the chosen return address |
| old_status | output | 32 | Status before the last interrupt on/off command |
| priv_mode | output | 2 | 0 kernel, 1 supervisor, 2 user, 3 error-kernel |
| lladdr | output | 32 | Load-linked reservation address |

## Verification
Two kinds of action can fall in the same cycle: a return that reads a return-address slot while a write lands in that same slot, and an exception return while a reservation write lands. The bench drives both inputs in the same cycle. It judges the result by requiring the redirect to carry the value from before the write and a later return to carry the new value. It also requires `lladdr` to read 1 after the non-keeping return and to read the written value after the keeping return. The dropped status write and the dropped debug entry that arrive alongside a command are judged through the status word read back later with the interrupt-off command and through `priv_mode`.

// File: rtl/xret_pkg.sv
package xret_pkg;
  typedef enum logic [2:0] {
    OP_IOFF      = 3'd0,
    OP_ION       = 3'd1,
    OP_XRET      = 3'd2,
    OP_XRET_KEEP = 3'd3,
    OP_DBGRET    = 3'd4
  } xret_op_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_USER = 2'd2,
    MODE_ERRK = 2'd3
  } priv_mode_e;

  localparam int unsigned ST_IE   = 0;
  localparam int unsigned ST_EXL  = 1;
  localparam int unsigned ST_ERL  = 2;
  localparam int unsigned ST_KSU0 = 3;
  localparam int unsigned ST_KSU1 = 4;

  localparam int unsigned NUM_RA   = 3;
  localparam int unsigned RA_SEL_W = $clog2(NUM_RA);
  localparam int unsigned RA_EXC   = 0;
  localparam int unsigned RA_ERR   = 1;
  localparam int unsigned RA_DBG   = 2;
endpackage

// File: rtl/xret_addr_bank.sv
module xret_addr_bank
  import xret_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [RA_SEL_W-1:0]            wr_sel,
  input  logic [W-1:0]                   wr_data,
  output logic [NUM_RA-1:0][W-1:0]       ra_q
);
  for (genvar i = 0; i < NUM_RA; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ra_q[i] <= '0;
      end else if (wr_en && (wr_sel == RA_SEL_W'(i))) begin
        ra_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/xret_status_unit.sv
module xret_status_unit
  import xret_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic         st_we,
  input  logic [W-1:0] st_wdata,
  input  logic         dbg_enter,
  output logic [W-1:0] status_q,
  output logic         dm_q,
  output logic [W-1:0] old_status_q,
  output logic [1:0]   mode
);
  localparam logic [W-1:0] ST_RESET = W'(1) << ST_ERL;

  xret_op_e op;
  assign op = xret_op_e'(cmd_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q     <= ST_RESET;
      dm_q         <= 1'b0;
      old_status_q <= '0;
    end else if (cmd_valid) begin
      case (op)
        OP_IOFF: begin
          old_status_q    <= status_q;
          status_q[ST_IE] <= 1'b0;
        end
        OP_ION: begin
          old_status_q    <= status_q;
          status_q[ST_IE] <= 1'b1;
        end
        OP_XRET, OP_XRET_KEEP: begin
          if (status_q[ST_ERL]) status_q[ST_ERL] <= 1'b0;
          else                  status_q[ST_EXL] <= 1'b0;
        end
        OP_DBGRET: dm_q <= 1'b0;
        default: ;
      endcase
    end else begin
      if (st_we)     status_q <= st_wdata;
      if (dbg_enter) dm_q     <= 1'b1;
    end
  end

  priv_mode_e mode_e;
  always_comb begin
    if (status_q[ST_ERL])                 mode_e = MODE_ERRK;
    else if (status_q[ST_EXL] || dm_q)    mode_e = MODE_KERN;
    else if (status_q[ST_KSU1])           mode_e = MODE_USER;
    else if (status_q[ST_KSU0])           mode_e = MODE_SUPV;
    else                                  mode_e = MODE_KERN;
  end
  assign mode = mode_e;

  assert_erl_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (op == OP_XRET || op == OP_XRET_KEEP) && status_q[ST_ERL])
    |=> (!status_q[ST_ERL] && status_q[ST_EXL] == $past(status_q[ST_EXL])));

  assert_exl_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (op == OP_XRET || op == OP_XRET_KEEP) && !status_q[ST_ERL])
    |=> (!status_q[ST_EXL] && !status_q[ST_ERL]));

  assert_dbg_keeps_levels_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_DBGRET)
    |=> (!dm_q && status_q[ST_ERL:ST_EXL] == $past(status_q[ST_ERL:ST_EXL])));

  assert_cmd_drops_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_DBGRET && dbg_enter) |=> !dm_q);
endmodule

// File: rtl/xret_redirect_unit.sv
module xret_redirect_unit
  import xret_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic                     erl,
  input  logic [NUM_RA-1:0][W-1:0] ra_q,
  input  logic                     ll_we,
  input  logic [W-1:0]             ll_wdata,
  output logic                     redir_valid,
  output logic [W-1:0]             redir_pc,
  output logic                     redir_isa,
  output logic [W-1:0]             lladdr
);
  localparam logic [W-1:0] LL_CLEARED = W'(1);

  xret_op_e op;
  assign op = xret_op_e'(cmd_op);

  logic         is_ret;
  logic [W-1:0] target;
  always_comb begin
    is_ret = 1'b0;
    target = ra_q[RA_EXC];
    case (op)
      OP_XRET, OP_XRET_KEEP: begin
        is_ret = 1'b1;
        target = erl ? ra_q[RA_ERR] : ra_q[RA_EXC];
      end
      OP_DBGRET: begin
        is_ret = 1'b1;
        target = ra_q[RA_DBG];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_isa   <= 1'b0;
    end else begin
      redir_valid <= cmd_valid && is_ret;
      if (cmd_valid && is_ret) begin
        redir_pc  <= {target[W-1:1], 1'b0};
        redir_isa <= target[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         lladdr <= LL_CLEARED;
    else if (cmd_valid && op == OP_XRET) lladdr <= LL_CLEARED;
    else if (ll_we)                      lladdr <= ll_wdata;
  end

  assert_ll_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_XRET) |=> (lladdr == LL_CLEARED));

  assert_ll_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_XRET_KEEP && !ll_we) |=> $stable(lladdr));

  assert_pc_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !redir_pc[0]);
endmodule

// File: rtl/xret_ctrl_unit.sv
module xret_ctrl_unit
  import xret_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic                st_we,
  input  logic [W-1:0]        st_wdata,
  input  logic                dbg_enter,
  input  logic                ra_we,
  input  logic [RA_SEL_W-1:0] ra_sel,
  input  logic [W-1:0]        ra_wdata,
  input  logic                ll_we,
  input  logic [W-1:0]        ll_wdata,
  output logic                redir_valid,
  output logic [W-1:0]        redir_pc,
  output logic                redir_isa,
  output logic [W-1:0]        old_status,
  output logic [1:0]          priv_mode,
  output logic [W-1:0]        lladdr
);
  logic [NUM_RA-1:0][W-1:0] ra_q;
  logic [W-1:0]             status_q;
  logic                     dm_q;

  xret_addr_bank #(.W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(ra_we), .wr_sel(ra_sel),
    .wr_data(ra_wdata), .ra_q(ra_q)
  );

  xret_status_unit #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .st_we(st_we), .st_wdata(st_wdata), .dbg_enter(dbg_enter),
    .status_q(status_q), .dm_q(dm_q), .old_status_q(old_status),
    .mode(priv_mode)
  );

  xret_redirect_unit #(.W(W)) u_redir (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .erl(status_q[ST_ERL]), .ra_q(ra_q), .ll_we(ll_we), .ll_wdata(ll_wdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_isa(redir_isa),
    .lladdr(lladdr)
  );

  assert_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_op == 3'd0 || cmd_op == 3'd1 || cmd_op > 3'd4) |=> !redir_valid);

  assert_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= 3'd2 && cmd_op <= 3'd4) |=> redir_valid);

  assert_errk_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[ST_ERL] |-> (priv_mode == 2'd3));
endmodule

// File: tb/xret_ctrl_unit_test.sv
`timescale 1ns/1ps
module xret_ctrl_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic         st_we = 1'b0;
  logic [W-1:0] st_wdata = '0;
  logic         dbg_enter = 1'b0;
  logic         ra_we = 1'b0;
  logic [1:0]   ra_sel = '0;
  logic [W-1:0] ra_wdata = '0;
  logic         ll_we = 1'b0;
  logic [W-1:0] ll_wdata = '0;
  logic         redir_valid, redir_isa;
  logic [W-1:0] redir_pc, old_status, lladdr;
  logic [1:0]   priv_mode;

  always #2 clk = ~clk;

  xret_ctrl_unit #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .st_we(st_we), .st_wdata(st_wdata), .dbg_enter(dbg_enter),
    .ra_we(ra_we), .ra_sel(ra_sel), .ra_wdata(ra_wdata),
    .ll_we(ll_we), .ll_wdata(ll_wdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_isa(redir_isa),
    .old_status(old_status), .priv_mode(priv_mode), .lladdr(lladdr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string ctx = "";

  logic [W-1:0] m_st, m_old, m_ll;
  logic         m_dm;
  logic [W-1:0] m_ra [3];

  task automatic cmp(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, ctx, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(logic [W-1:0] st, logic dm);
    if (st[2])        return 2'd3;
    if (st[1] || dm)  return 2'd0;
    if (st[4])        return 2'd2;
    if (st[3])        return 2'd1;
    return 2'd0;
  endfunction

  // One clock: captures driven inputs, updates the model, checks outputs.
  task automatic tick();
    int           op;
    logic         is_ret;
    logic [W-1:0] tgt;
    string        ptag;
    op     = int'(cmd_op);
    is_ret = cmd_valid && (op >= 2) && (op <= 4);
    tgt    = '0;
    ptag   = "R9";
    if (cmd_valid && (op == 2 || op == 3)) begin
      tgt  = m_st[2] ? m_ra[1] : m_ra[0];
      ptag = m_st[2] ? "R4" : "R5";
    end else if (cmd_valid && op == 4) begin
      tgt  = m_ra[2];
      ptag = "R7";
    end
    @(posedge clk);
    @(negedge clk);
    if (cmd_valid) begin
      case (op)
        0: begin m_old = m_st; m_st[0] = 1'b0; end
        1: begin m_old = m_st; m_st[0] = 1'b1; end
        2, 3: begin
          if (m_st[2]) m_st[2] = 1'b0; else m_st[1] = 1'b0;
          if (op == 2) m_ll = W'(1);
        end
        4: m_dm = 1'b0;
        default: ;
      endcase
    end else begin
      if (st_we)     m_st = st_wdata;   // R12
      if (dbg_enter) m_dm = 1'b1;       // R12
    end
    if (ra_we && ra_sel < 2'd3) m_ra[ra_sel] = ra_wdata;
    if (ll_we && !(cmd_valid && op == 2)) m_ll = ll_wdata;

    cmp("R9", W'(redir_valid), W'(is_ret));
    if (is_ret) begin
      cmp(ptag, redir_pc, {tgt[W-1:1], 1'b0});
      cmp("R10", W'(redir_isa), W'(tgt[0]));
    end
    cmp("R6", lladdr, m_ll);
    cmp("R8", W'(priv_mode), W'(exp_mode(m_st, m_dm)));
    cmp((cmd_valid && op == 1) ? "R3" : "R2", old_status, m_old);
    cmd_valid = 1'b0; st_we = 1'b0; dbg_enter = 1'b0; ra_we = 1'b0; ll_we = 1'b0;
  endtask

  task automatic do_cmd(int op);
    cmd_valid = 1'b1; cmd_op = 3'(op); tick();
  endtask
  task automatic set_st(logic [W-1:0] v);
    st_we = 1'b1; st_wdata = v; tick();
  endtask
  task automatic set_ra(int i, logic [W-1:0] v);
    ra_we = 1'b1; ra_sel = 2'(i); ra_wdata = v; tick();
  endtask
  task automatic set_ll(logic [W-1:0] v);
    ll_we = 1'b1; ll_wdata = v; tick();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    m_st = W'(4); m_old = '0; m_ll = W'(1); m_dm = 1'b0;
    for (int i = 0; i < 3; i++) m_ra[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    ctx = "reset R1";
    cmp("R1", W'(redir_valid), '0);
    cmp("R1", lladdr, W'(1));
    cmp("R1", W'(priv_mode), W'(3));
    do_cmd(0);   // old_status reveals the reset status word
    cmp("R1", old_status, W'(4));

    // Sweep: status low bits x debug flag x every command code
    for (int s = 0; s < 32; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int op = 0; op < 8; op++) begin
          ctx = $sformatf("sweep s=%0d d=%0d op=%0d", s, d, op);
          for (int i = 0; i < 3; i++)
            set_ra(i, 32'h8000_0000 + (s << 12) + (i << 8) + (d << 4) + ((s + i + op) & 1));
          set_st(32'hC3A5_0000 | W'(s));
          if (d == 1) begin dbg_enter = 1'b1; tick(); end
          set_ll(32'h00AB_C000 | W'(s << 4) | W'(op));
          do_cmd(op);
          do_cmd(0);   // read back status after the command (R2)
        end
      end
    end

    // R11: return-address write in the same cycle as the return
    ctx = "R11 slot write with return";
    set_ra(0, 32'h1111_1110);
    set_st(32'h0000_0002);
    ra_we = 1'b1; ra_sel = 2'd0; ra_wdata = 32'h2222_2223;
    do_cmd(2);
    set_st(32'h0000_0002);
    do_cmd(3);   // must now carry the new value
    set_ra(1, 32'h3333_3330);
    set_st(32'h0000_0006);
    ra_we = 1'b1; ra_sel = 2'd1; ra_wdata = 32'h4444_4441;
    do_cmd(2);
    dbg_enter = 1'b1; tick();
    set_ra(2, 32'h5555_5555);
    ra_we = 1'b1; ra_sel = 2'd2; ra_wdata = 32'h6666_6666;
    do_cmd(4);
    dbg_enter = 1'b1; tick();
    do_cmd(4);

    // R11: status write and debug entry dropped alongside a command
    ctx = "R11 dropped writes";
    set_st(32'h0000_0010);
    st_we = 1'b1; st_wdata = 32'hFFFF_FFFF;
    do_cmd(1);
    do_cmd(0);
    dbg_enter = 1'b1;
    do_cmd(0);
    dbg_enter = 1'b1;
    do_cmd(6);

    // R6: reservation write racing the two return flavours
    ctx = "R6 ll race";
    set_ll(32'h0000_BEE0);
    set_st(32'h0000_0002);
    ll_we = 1'b1; ll_wdata = 32'h0000_CAF0;
    do_cmd(2);
    set_ll(32'h0000_1230);
    set_st(32'h0000_0002);
    ll_we = 1'b1; ll_wdata = 32'h0000_4560;
    do_cmd(3);
    set_st(32'h0000_0002);
    do_cmd(3);

    // R9: back-to-back returns give back-to-back strobes, then quiet
    ctx = "R9 back to back";
    do_cmd(4);
    do_cmd(4);
    tick();
    do_cmd(5);
    do_cmd(7);

    done = 1'b1;
    report();
    $finish;
  end
endmodule